// File: doc/BRIEF.md
# Trunk Egress Port Selector

This block picks one physical member port of a link-aggregation trunk group for each frame sent toward that group. Traffic spreads across the members, and every frame of one flow lands on the same port, so order within a flow is kept. A request carries the target group number, the frame's source and destination MAC addresses and its ingress port number. Each group has its own configuration: a list of member ports, a member count and a key mode.

Group 0 is the gigabit group, which holds the two gigabit ports. Groups 1 and 2 are 10/100 groups of up to four members each. The key is built from the selected addresses and folded by XOR into a short hash: 2 bits for a 10/100 group, 1 bit for the gigabit group. The hash is reduced modulo the member count and then indexes the member list. The result is registered, so it comes out exactly one cycle after the request.

Top module: `trunk_egress_sel`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sel_valid` is 0 and `sel_port` is 0.
- R2: A request sampled with `req_valid` high at a rising edge is answered on the outputs right after that edge. A cycle with no request gives `sel_valid` 0 and `sel_port` 0, and `sel_port` is 0 whenever `sel_valid` is 0.
- R3: Mode code 0 keys on the source MAC. A 10/100 group XORs the 24 two-bit slices `mac[2k+1:2k]` into a 2-bit hash. The gigabit group takes the XOR of all 48 bits as a 1-bit hash.
- R4: Mode code 1 keys on the destination MAC and is folded the same way as R3.
- R5: Mode code 2 keys on the bitwise XOR of source and destination MAC and is folded the same way as R3.
- R6: Mode code 3 on the gigabit group (group 0) keys on the 5-bit ingress port number, folded by XOR of all its bits into 1 bit. On a 10/100 group, mode code 3 behaves exactly like mode code 2.
- R7: The member slot is the hash modulo the effective member count. The port is read from slot s of group g at `cfg_members[(g*4+s)*5 +: 5]`. Counts that are not a power of two, such as 3, use a true remainder.
- R8: A request to a group whose count field (`cfg_count[g*3 +: 3]`) is 0 gives `sel_valid` 0.
- R9: A count field greater than 4 is treated as 4.
- R10: A request with `req_group` 3, which names no group, gives `sel_valid` 0.
- R11: Repeated requests with the same key fields and the same configuration always return the same port.
- R12: The mode of group g is `cfg_mode[g*2 +: 2]`. Configuration is sampled in the same cycle as the request, so a change made in the request cycle governs that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_group | input | 2 | Target trunk group number |
| req_smac | input | 48 | Frame source MAC address |
| req_dmac | input | 48 | Frame destination MAC address |
| req_ingress | input | 5 | Port the frame arrived on |
| cfg_members | input | 60 | Member port numbers, 4 slots x 5 bits per group |
| cfg_count | input | 9 | Member count, 3 bits per group |
| cfg_mode | input | 6 | Key mode, 2 bits per group |
| sel_valid | output | 1 | Selected port is valid |
| sel_port | output | 5 | Selected physical port |

## Verification
Two things can happen in the same cycle: a configuration change and a request that uses the group being changed. The bench provokes this by rewriting a group's count, members or mode on the very edge it presents a request to that group. It expects the new configuration to decide that response, including a count dropped to zero in the request cycle. The behavioural reference model reads the configuration as it stands when the request is driven and is compared on every clock. It also covers back-to-back requests that alternate between the gigabit and 10/100 hashing paths.

// File: rtl/trunk_sel_pkg.sv
`timescale 1ns/1ps
package trunk_sel_pkg;

   // Key-mode encodings shared by all lanes
   typedef enum logic [1:0] {
      KEY_SRC     = 2'd0,
      KEY_DST     = 2'd1,
      KEY_BOTH    = 2'd2,
      KEY_INGRESS = 2'd3
   } key_mode_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/trunk_key_fold.sv
`timescale 1ns/1ps
// XOR-folds an IN_W vector into OUT_W bits, slice k = bits [k*OUT_W +: OUT_W]
module trunk_key_fold #(
   parameter int IN_W  = 48,
   parameter int OUT_W = 2
) (
   input  logic [IN_W-1:0]  fold_in,
   output logic [OUT_W-1:0] fold_out
);
   localparam int NCH   = (IN_W + OUT_W - 1) / OUT_W;
   localparam int PAD_W = NCH * OUT_W;

   if (OUT_W < 1 || OUT_W > IN_W) begin : g_bad_w
      $error("trunk_key_fold: OUT_W must lie in 1..IN_W");
   end

   logic [PAD_W-1:0] padded;

   always_comb begin
      padded   = PAD_W'(fold_in);
      fold_out = '0;
      for (int k = 0; k < NCH; k++) begin
         fold_out = fold_out ^ padded[k*OUT_W +: OUT_W];
      end
   end
endmodule

// File: rtl/trunk_key_build.sv
`timescale 1ns/1ps
// Builds the folded hash for one group from the request fields and mode
module trunk_key_build
   import trunk_sel_pkg::*;
#(
   parameter int MAC_W         = 48,
   parameter int PORT_W        = 5,
   parameter int HASH_W        = 2,
   parameter bit ALLOW_INGRESS = 1'b0
) (
   input  logic [1:0]        mode,
   input  logic [MAC_W-1:0]  smac,
   input  logic [MAC_W-1:0]  dmac,
   input  logic [PORT_W-1:0] ingress,
   output logic [HASH_W-1:0] hash
);
   localparam int PF_W = (HASH_W > PORT_W) ? PORT_W : HASH_W;

   logic [MAC_W-1:0]  mac_key;
   logic [HASH_W-1:0] mac_hash;
   logic [PF_W-1:0]   port_fold;
   key_mode_e         kmode;

   assign kmode = key_mode_e'(mode);

   always_comb begin
      unique case (kmode)
         KEY_SRC: mac_key = smac;
         KEY_DST: mac_key = dmac;
         default: mac_key = smac ^ dmac;
      endcase
   end

   trunk_key_fold #(.IN_W(MAC_W), .OUT_W(HASH_W)) u_mac_fold (
      .fold_in (mac_key),
      .fold_out(mac_hash)
   );

   trunk_key_fold #(.IN_W(PORT_W), .OUT_W(PF_W)) u_port_fold (
      .fold_in (ingress),
      .fold_out(port_fold)
   );

   if (ALLOW_INGRESS) begin : g_ingress
      always_comb begin
         if (kmode == KEY_INGRESS) hash = HASH_W'(port_fold);
         else                      hash = mac_hash;
      end
   end else begin : g_mac_only
      logic unused_fold;
      assign unused_fold = ^port_fold;
      assign hash        = mac_hash;
   end
endmodule

// File: rtl/trunk_member_pick.sv
`timescale 1ns/1ps
// Clamps the count, reduces the hash modulo it, and reads the member slot
module trunk_member_pick
   import trunk_sel_pkg::*;
#(
   parameter int PORT_W      = 5,
   parameter int MAX_MEMBERS = 4,
   parameter int HASH_W      = 2,
   parameter int CNT_W       = 3
) (
   input  logic [HASH_W-1:0]             hash,
   input  logic [CNT_W-1:0]              count,
   input  logic [MAX_MEMBERS*PORT_W-1:0] members,
   output logic [PORT_W-1:0]             port,
   output logic                          ok
);
   localparam int W = imax(HASH_W, CNT_W);

   logic [CNT_W-1:0] eff;
   logic [W-1:0]     rem;

   always_comb begin
      eff = (count > CNT_W'(MAX_MEMBERS)) ? CNT_W'(MAX_MEMBERS) : count;
      ok  = (eff != '0);
      rem = ok ? (W'(hash) % W'(eff)) : '0;
      port = '0;
      for (int s = 0; s < MAX_MEMBERS; s++) begin
         if (rem == W'(s)) port = members[s*PORT_W +: PORT_W];
      end
   end
endmodule

// File: rtl/trunk_egress_sel.sv
`timescale 1ns/1ps
module trunk_egress_sel
   import trunk_sel_pkg::*;
#(
   parameter int  MAC_W       = 48,
   parameter int  PORT_W      = 5,
   parameter int  NUM_GROUPS  = 3,
   parameter int  MAX_MEMBERS = 4,
   parameter int  FE_HASH_W   = 2,
   parameter int  GIG_HASH_W  = 1,
   parameter int  GIG_GROUP   = 0,
   localparam int GRP_W       = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS + 1) : 1,
   localparam int CNT_W       = $clog2(MAX_MEMBERS + 1)
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     req_valid,
   input  logic [GRP_W-1:0]                         req_group,
   input  logic [MAC_W-1:0]                         req_smac,
   input  logic [MAC_W-1:0]                         req_dmac,
   input  logic [PORT_W-1:0]                        req_ingress,
   input  logic [NUM_GROUPS*MAX_MEMBERS*PORT_W-1:0] cfg_members,
   input  logic [NUM_GROUPS*CNT_W-1:0]              cfg_count,
   input  logic [NUM_GROUPS*2-1:0]                  cfg_mode,
   output logic                                     sel_valid,
   output logic [PORT_W-1:0]                        sel_port
);
   localparam int SLOT_W = MAX_MEMBERS * PORT_W;

   // elaboration-time parameter checks
   if (MAX_MEMBERS < 2)                      begin : g_chk_mem  $error("MAX_MEMBERS must be at least 2"); end
   if (GIG_GROUP < 0 || GIG_GROUP >= NUM_GROUPS) begin : g_chk_gig $error("GIG_GROUP out of range"); end
   if (FE_HASH_W < 1 || GIG_HASH_W < 1)      begin : g_chk_hash $error("hash widths must be positive"); end
   if (NUM_GROUPS < 1)                       begin : g_chk_grp  $error("NUM_GROUPS must be positive"); end

   logic [PORT_W-1:0] lane_port [NUM_GROUPS];
   logic              lane_ok   [NUM_GROUPS];

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lane
      localparam bit IS_GIG = (g == GIG_GROUP);
      localparam int HW     = IS_GIG ? GIG_HASH_W : FE_HASH_W;

      logic [HW-1:0] lane_hash;

      trunk_key_build #(
         .MAC_W(MAC_W), .PORT_W(PORT_W), .HASH_W(HW), .ALLOW_INGRESS(IS_GIG)
      ) u_key (
         .mode   (cfg_mode[g*2 +: 2]),
         .smac   (req_smac),
         .dmac   (req_dmac),
         .ingress(req_ingress),
         .hash   (lane_hash)
      );

      trunk_member_pick #(
         .PORT_W(PORT_W), .MAX_MEMBERS(MAX_MEMBERS), .HASH_W(HW), .CNT_W(CNT_W)
      ) u_pick (
         .hash   (lane_hash),
         .count  (cfg_count[g*CNT_W +: CNT_W]),
         .members(cfg_members[g*SLOT_W +: SLOT_W]),
         .port   (lane_port[g]),
         .ok     (lane_ok[g])
      );
   end

   // group select
   logic              hit_ok;
   logic [PORT_W-1:0] hit_port;
   logic [CNT_W-1:0]  grp_cnt_raw;

   always_comb begin
      hit_ok      = 1'b0;
      hit_port    = '0;
      grp_cnt_raw = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (int'(req_group) == g) begin
            hit_ok      = lane_ok[g];
            hit_port    = lane_port[g];
            grp_cnt_raw = cfg_count[g*CNT_W +: CNT_W];
         end
      end
   end

   // single output register stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_valid <= 1'b0;
         sel_port  <= '0;
      end else begin
         sel_valid <= req_valid && hit_ok;
         sel_port  <= (req_valid && hit_ok) ? hit_port : '0;
      end
   end

   // R2
   sel_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> $past(req_valid));

   // R2
   idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |-> (sel_port == '0));

   // R8
   zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(req_valid) && ($past(grp_cnt_raw) == '0)) |-> !sel_valid);

   // R10
   bad_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_valid) && (int'($past(req_group)) >= NUM_GROUPS)) |-> !sel_valid);

   // R11
   same_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && req_valid && $past(req_valid) && $stable(req_group) &&
       $stable(req_smac) && $stable(req_dmac) && $stable(req_ingress) &&
       $stable(cfg_members) && $stable(cfg_count) && $stable(cfg_mode))
      |=> ($stable(sel_port) && $stable(sel_valid)));
endmodule

// File: tb/tb_trunk_egress_sel.sv
`timescale 1ns/1ps
module tb_trunk_egress_sel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_group = '0;
   logic [47:0] req_smac = '0;
   logic [47:0] req_dmac = '0;
   logic [4:0]  req_ingress = '0;
   logic [59:0] cfg_members;
   logic [8:0]  cfg_count;
   logic [5:0]  cfg_mode;
   logic        sel_valid;
   logic [4:0]  sel_port;

   logic [4:0] mem_t [3][4];
   logic [2:0] cnt_t [3];
   logic [1:0] mode_t [3];

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   always_comb begin
      for (int g = 0; g < 3; g++) begin
         cfg_count[g*3 +: 3] = cnt_t[g];
         cfg_mode[g*2 +: 2]  = mode_t[g];
         for (int s = 0; s < 4; s++) cfg_members[(g*4+s)*5 +: 5] = mem_t[g][s];
      end
   end

   trunk_egress_sel dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_group(req_group),
      .req_smac(req_smac), .req_dmac(req_dmac), .req_ingress(req_ingress),
      .cfg_members(cfg_members), .cfg_count(cfg_count), .cfg_mode(cfg_mode),
      .sel_valid(sel_valid), .sel_port(sel_port)
   );

   function automatic int fold2(input logic [47:0] k);
      int h = 0;
      for (int i = 0; i < 24; i++) h = h ^ int'(k[2*i +: 2]);
      return h;
   endfunction

   task automatic check(input string tag, input bit ev, input int ep);
      compared++;
      if (sel_valid !== ev || int'(sel_port) != ep) begin
         mismatched++;
         $display("FAIL %s: valid=%0b port=%0d expected valid=%0b port=%0d",
                  tag, sel_valid, sel_port, ev, ep);
      end
   endtask

   // drive one request at a negedge, compare at the next negedge
   task automatic step(input bit v, input int g, input logic [47:0] s,
                       input logic [47:0] d, input int ip, input string force_tag);
      bit    ev = 1'b0;
      int    ep = 0;
      int    h, eff, md;
      string tag;
      logic [47:0] key;
      req_valid = v; req_group = 2'(g); req_smac = s; req_dmac = d; req_ingress = 5'(ip);
      if (!v)            tag = "R2";
      else if (g >= 3)   tag = "R10";
      else begin
         md  = int'(mode_t[g]);
         eff = int'(cnt_t[g]);
         if (eff > 4) eff = 4;
         if (md == 0) key = s; else if (md == 1) key = d; else key = s ^ d;
         if (g == 0) h = (md == 3) ? int'(^req_ingress) : int'(^key);
         else        h = fold2(key);
         if (eff == 0) tag = "R8";
         else begin
            ev = 1'b1;
            ep = int'(mem_t[g][h % eff]);
            if (cnt_t[g] > 4)       tag = "R9";
            else if (eff == 3)      tag = "R7";
            else if (md == 3)       tag = "R6";
            else if (md == 0)       tag = "R3";
            else if (md == 1)       tag = "R4";
            else                    tag = "R5";
         end
      end
      if (force_tag != "") tag = force_tag;
      @(negedge clk);
      check(tag, ev, ep);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      logic [47:0] a, b;
      logic [4:0]  first_port;
      for (int g = 0; g < 3; g++) begin
         cnt_t[g] = 3'd0; mode_t[g] = 2'd0;
         for (int sl = 0; sl < 4; sl++) mem_t[g][sl] = 5'(g*8 + sl);
      end
      mem_t[0][0] = 5'd24; mem_t[0][1] = 5'd25;
      repeat (2) @(negedge clk);
      check("R1", 1'b0, 0);
      rst_n = 1'b1;
      step(1'b0, 0, '0, '0, 0, "R1");

      // gigabit group on ingress port
      cnt_t[0] = 3'd2; mode_t[0] = 2'd3;
      for (int ip = 0; ip < 6; ip++) step(1'b1, 0, 48'h1234_5678_9abc, 48'h0, ip, "");
      // 10/100 group 1: source, destination, both
      cnt_t[1] = 3'd4;
      for (int md = 0; md < 4; md++) begin
         mode_t[1] = 2'(md);
         for (int k = 0; k < 4; k++)
            step(1'b1, 1, 48'(k * 48'h0101_0000_0003), 48'(k * 48'h0000_0402_0001), 0, "");
      end
      // group 2 with count 3 (true remainder)
      cnt_t[2] = 3'd3; mode_t[2] = 2'd1;
      for (int k = 0; k < 4; k++) step(1'b1, 2, 48'h0, 48'(k), 0, "R7");
      // count above 4 clamps
      cnt_t[1] = 3'd7; mode_t[1] = 2'd0;
      for (int k = 0; k < 4; k++) step(1'b1, 1, 48'(k), 48'h0, 0, "R9");
      // no such group
      step(1'b1, 3, 48'h3, 48'h1, 0, "R10");
      // config change in the request cycle (R12)
      cnt_t[2] = 3'd0;
      step(1'b1, 2, 48'h0, 48'h2, 0, "R12");
      cnt_t[2] = 3'd2; mem_t[2][1] = 5'd17; mode_t[2] = 2'd0;
      step(1'b1, 2, 48'h1, 48'h0, 0, "R12");
      // idle cycle
      step(1'b0, 1, 48'h5, 48'h5, 0, "R2");
      // same key repeated
      cnt_t[1] = 3'd4; mode_t[1] = 2'd2;
      step(1'b1, 1, 48'hdead_beef_0042, 48'h0bad_cafe_1234, 3, "R11");
      first_port = sel_port;
      for (int r = 0; r < 3; r++) begin
         step(1'b1, 1, 48'hdead_beef_0042, 48'h0bad_cafe_1234, 3, "R11");
         compared++;
         if (sel_port !== first_port) begin
            mismatched++;
            $display("FAIL R11: port=%0d expected port=%0d", sel_port, first_port);
         end
      end
      // random traffic with periodic reconfiguration
      for (int n = 0; n < 4000; n++) begin
         if (n % 50 == 0) begin
            for (int g = 0; g < 3; g++) begin
               cnt_t[g]  = 3'($urandom_range(0, 7));
               mode_t[g] = 2'($urandom_range(0, 3));
               for (int sl = 0; sl < 4; sl++) mem_t[g][sl] = 5'($urandom_range(0, 25));
            end
         end
         a = 48'({$urandom(), $urandom()});
         b = 48'({$urandom(), $urandom()});
         step(($urandom_range(0, 7) != 0), int'($urandom_range(0, 3)), a, b,
              int'($urandom_range(0, 25)), "");
      end
      finish_run();
   end
endmodule